// File: doc/BRIEF.md
# Resampler Input Sample Buffer with Programmable Read Offset

This block is the input-side sample store of an asynchronous sample rate converter. Every input strobe writes one stereo pair into a circular buffer of 512 entries per channel. The left and right words are interleaved, so a flat word address carries the channel in its least significant bit. A convolution engine reads any stored word through a random-access port. A servo steps a read reference through the buffer and aligns to the reported write address.

An 8-bit control word places the read reference a set distance behind the write pointer. The distance is a fixed 16 samples plus a 7-bit extra amount. A larger distance keeps the two pointers apart when the rate ratio drifts. Writing the control word realigns the read reference to that distance and clears the crossing flag. The top bit of the same word requests a soft mute. The mute lowers the readout gain by one sixty-fourth per output-sample tick until the gain reaches zero. When the bit is cleared, the gain climbs back to unity in the same steps.

Top module: `rsf_input_fifo`

## Requirements
- R1: After reset, wr_addr is 0, rd_base is 496 (512 minus 16), fill is 16, overrun is 0, muted is 0 and the readout gain is unity.
- R2: A cycle with in_valid high and fill below 511 stores in_left at word address {wr_addr,0} and in_right at {wr_addr,1}, and increments wr_addr.
- R3: rd_data carries the word stored at rd_addr one clock after rd_addr is presented. Address bit 0 selects the channel: 0 is left, 1 is right.
- R4: A cycle with cfg_we high sets the offset to 16 plus cfg_data[6:0]. From the next cycle, rd_base equals wr_addr minus the offset modulo 512, fill equals the offset, and overrun is 0.
- R5: rd_step with fill above 0 advances rd_base by one and lowers fill by one. Each accepted write raises fill by one.
- R6: rd_step while fill is 0 leaves rd_base unchanged and sets overrun. Overrun stays set until the next cfg_we.
- R7: A write while fill is 511 is dropped: wr_addr and fill are unchanged and overrun is set.
- R8: While cfg_data[7] was last written as 1, each out_tick lowers the gain by 1/64 until it reaches zero. rd_data is the stored word times the gain, rounded toward minus infinity. After 64 ticks, rd_data is 0 and muted is 1.
- R9: While cfg_data[7] was last written as 0, each out_tick raises the gain by 1/64 up to unity, and muted is 0 once the gain is above zero.
- R10: wr_addr and rd_base wrap from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input stereo pair strobe |
| in_left | input | 24 | Left input sample |
| in_right | input | 24 | Right input sample |
| cfg_we | input | 1 | Control word write strobe |
| cfg_data | input | 8 | Bit 7 soft mute, bits 6..0 extra offset |
| rd_addr | input | 10 | Readout word address, bit 0 selects channel |
| rd_data | output | 24 | Gain-scaled readout word |
| rd_step | input | 1 | Advance the read reference by one sample |
| out_tick | input | 1 | Output-sample tick that steps the mute ramp |
| wr_addr | output | 9 | Current write pointer |
| rd_base | output | 9 | Current read reference |
| fill | output | 10 | Samples between read reference and write pointer |
| overrun | output | 1 | Sticky pointer-crossing flag |
| muted | output | 1 | Gain has reached zero |

## Verification
The bench builds the block with its default parameters: 512 entries per channel, 24-bit samples, a base offset of 16 and a 64-tick ramp. With the base offset at 16, about 500 writes reach a full buffer, so the dropped-write path and pointer wrap-around are both exercised. The 64-tick ramp lets the bench check the gain at its half-way point, where the expected values are exact, and at both of its ends.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int CFG_W   = 8;
  localparam int EXTRA_W = 7;

  typedef struct packed {
    logic                soft_mute;
    logic [EXTRA_W-1:0]  extra;
  } rsf_cfg_t;
endpackage

// File: rtl/rsf_ptr_ctrl.sv
module rsf_ptr_ctrl #(
  parameter int DEPTH    = 512,
  parameter int BASE_OFS = 16,
  parameter int EXTRA_W  = 7,
  localparam int AW      = $clog2(DEPTH),
  localparam int FW      = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               step,
  input  logic               cfg_we,
  input  logic [EXTRA_W-1:0] extra,
  output logic               wr_ok,
  output logic [AW-1:0]      wr_ptr,
  output logic [AW-1:0]      rd_ptr,
  output logic [FW-1:0]      fill,
  output logic               overrun
);
  localparam logic [AW-1:0] RD_RST   = AW'(DEPTH - BASE_OFS);
  localparam logic [FW-1:0] FILL_RST = FW'(BASE_OFS);
  localparam logic [FW-1:0] FILL_MAX = FW'(DEPTH - 1);

  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [FW-1:0] fill_q, fill_n, offs;
  logic          ovr_q, ovr_n, full, empty, st_ok;

  always_comb begin
    offs  = FW'(BASE_OFS) + FW'(extra);
    full  = (fill_q == FILL_MAX);
    empty = (fill_q == '0);
    wr_ok = wr_en && !full;
    st_ok = step && !empty;
    wr_n  = wr_q + AW'(wr_ok);
    if (cfg_we) begin
      rd_n   = wr_q - offs[AW-1:0];
      fill_n = offs + FW'(wr_ok);
      ovr_n  = 1'b0;
    end else begin
      rd_n   = rd_q + AW'(st_ok);
      fill_n = fill_q + FW'(wr_ok) - FW'(st_ok);
      ovr_n  = ovr_q | (step && empty) | (wr_en && full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= RD_RST;
      fill_q <= FILL_RST;
      ovr_q  <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      fill_q <= fill_n;
      ovr_q  <= ovr_n;
    end
  end

  assign wr_ptr  = wr_q;
  assign rd_ptr  = rd_q;
  assign fill    = fill_q;
  assign overrun = ovr_q;

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX); // R7
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill_q != FILL_MAX) |=> (wr_q == $past(wr_q) + AW'(1))); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill_q == FILL_MAX) |=> (wr_q == $past(wr_q))); // R7
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_we && fill_q != '0) |=> (rd_q == $past(rd_q) + AW'(1))); // R5
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_we && fill_q == '0) |=> (rd_q == $past(rd_q) && ovr_q)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !cfg_we) |=> ovr_q); // R6
  AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!ovr_q && (wr_q - rd_q) == $past(offs[AW-1:0]) + AW'($past(wr_ok)))); // R4
endmodule

// File: rtl/rsf_store.sv
module rsf_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 24,
  localparam int AW   = $clog2(DEPTH),
  localparam int CH   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wd_left,
  input  logic [DW-1:0] wd_right,
  input  logic [AW:0]   rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] wd [CH];
  logic [DW-1:0] bank_q [CH];
  logic          ch_q;

  assign wd[0] = wd_left;
  assign wd[1] = wd_right;

  for (genvar c = 0; c < CH; c++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[wr_idx] <= wd[c];
    end
    always_ff @(posedge clk) begin
      bank_q[c] <= mem[rd_addr[AW:1]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= 1'b0;
    else        ch_q <= rd_addr[0];
  end

  assign rd_q = bank_q[ch_q];
endmodule

// File: rtl/rsf_mute.sv
module rsf_mute #(
  parameter int DW   = 24,
  parameter int RAMP = 64,
  localparam int SH  = $clog2(RAMP),
  localparam int GW  = SH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mute,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          muted
);
  localparam logic [GW-1:0] G_MAX = GW'(RAMP);

  logic [GW-1:0] g_q, g_n;

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] s, input logic [GW-1:0] g);
    logic signed [DW+GW:0] p;
    p = $signed({{(GW+1){s[DW-1]}}, s}) * $signed({{(DW+1){1'b0}}, g});
    p = p >>> SH;
    return p[DW-1:0];
  endfunction

  always_comb begin
    g_n = g_q;
    if (tick) begin
      if (mute && g_q != '0)       g_n = g_q - GW'(1);
      else if (!mute && g_q < G_MAX) g_n = g_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g_q <= G_MAX;
    else        g_q <= g_n;
  end

  assign dout  = scale(din, g_q);
  assign muted = (g_q == '0);

  AST_GAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    g_q <= G_MAX); // R8
  AST_GAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mute && g_q != '0) |=> (g_q == $past(g_q) - GW'(1))); // R8
  AST_GAIN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mute && g_q != G_MAX) |=> (g_q == $past(g_q) + GW'(1))); // R9
  AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(g_q)); // R9
endmodule

// File: rtl/rsf_input_fifo.sv
module rsf_input_fifo #(
  parameter int DEPTH    = 512,
  parameter int DW       = 24,
  parameter int BASE_OFS = 16,
  parameter int RAMP     = 64,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DW-1:0]           in_left,
  input  logic [DW-1:0]           in_right,
  input  logic                    cfg_we,
  input  logic [rsf_pkg::CFG_W-1:0] cfg_data,
  input  logic [AW:0]             rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic                    rd_step,
  input  logic                    out_tick,
  output logic [AW-1:0]           wr_addr,
  output logic [AW-1:0]           rd_base,
  output logic [AW:0]             fill,
  output logic                    overrun,
  output logic                    muted
);
  import rsf_pkg::*;

  rsf_cfg_t      cfg;
  logic          mute_q, mute_n, wr_ok;
  logic [AW-1:0] wr_ptr;
  logic [DW-1:0] rd_raw;

  assign cfg    = rsf_cfg_t'(cfg_data);
  assign mute_n = cfg_we ? cfg.soft_mute : mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= mute_n;
  end

  rsf_ptr_ctrl #(.DEPTH(DEPTH), .BASE_OFS(BASE_OFS), .EXTRA_W(EXTRA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .step(rd_step),
    .cfg_we(cfg_we), .extra(cfg.extra), .wr_ok(wr_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_base), .fill(fill), .overrun(overrun)
  );

  rsf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .wr_idx(wr_ptr),
    .wd_left(in_left), .wd_right(in_right), .rd_addr(rd_addr), .rd_q(rd_raw)
  );

  rsf_mute #(.DW(DW), .RAMP(RAMP)) u_mute (
    .clk(clk), .rst_n(rst_n), .tick(out_tick), .mute(mute_q),
    .din(rd_raw), .dout(rd_data), .muted(muted)
  );

  assign wr_addr = wr_ptr;

  AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !out_tick) |=> $stable(muted)); // R8
endmodule

// File: tb/rsf_input_fifo_bench.sv
module rsf_input_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, cfg_we = 1'b0, rd_step = 1'b0, out_tick = 1'b0;
  logic [23:0] in_left = '0, in_right = '0, rd_data;
  logic [7:0]  cfg_data = '0;
  logic [9:0]  rd_addr = '0, fill;
  logic [8:0]  wr_addr, rd_base;
  logic        overrun, muted;

  int errors = 0, checks = 0;
  int exp_wr = 0, exp_rd = 496, exp_fill = 16;
  bit done = 0;

  always #10 clk = ~clk;

  rsf_input_fifo u_rsf_input_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .cfg_we(cfg_we), .cfg_data(cfg_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_step(rd_step), .out_tick(out_tick), .wr_addr(wr_addr), .rd_base(rd_base),
    .fill(fill), .overrun(overrun), .muted(muted)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ptrs(input string req);
    chk({req, " wr_addr"}, wr_addr, exp_wr);
    chk({req, " rd_base"}, rd_base, exp_rd);
    chk({req, " fill"}, fill, exp_fill);
  endtask

  task automatic do_write(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk); in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic do_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_data = v;
    @(negedge clk); cfg_we = 1'b0;
    exp_fill = 16 + int'(v[6:0]);
    exp_rd = (exp_wr - exp_fill + 512) % 512;
  endtask

  task automatic do_step();
    @(negedge clk); rd_step = 1'b1;
    @(negedge clk); rd_step = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    @(negedge clk); out_tick = 1'b1;
    repeat (n) @(negedge clk);
    out_tick = 1'b0;
  endtask

  task automatic read_word(input logic [9:0] a, output logic [23:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset();
    chk_ptrs("R1");
    chk("R1 overrun", overrun, 0);
    chk("R1 muted", muted, 0);
  endtask

  task automatic t_write_read();
    logic [23:0] d;
    for (int i = 0; i < 4; i++) begin
      do_write(24'(100 + i), 24'(200 + i));
      exp_wr++; exp_fill++;
    end
    chk_ptrs("R2 R5 writes");
    for (int i = 0; i < 4; i++) begin
      read_word(10'(2 * i), d);
      chk("R3 left", d, 100 + i);
      read_word(10'(2 * i + 1), d);
      chk("R3 right", d, 200 + i);
    end
  endtask

  task automatic t_offset();
    do_cfg(8'd5);
    chk_ptrs("R4 extra 5");
    do_cfg(8'd127);
    chk_ptrs("R4 extra 127");
    chk("R4 overrun", overrun, 0);
  endtask

  task automatic t_step();
    for (int i = 0; i < 3; i++) begin
      do_step();
      exp_rd = (exp_rd + 1) % 512; exp_fill--;
    end
    chk_ptrs("R5 steps");
  endtask

  task automatic t_overrun();
    do_cfg(8'd0);
    for (int i = 0; i < 16; i++) begin
      do_step();
      exp_rd = (exp_rd + 1) % 512; exp_fill--;
    end
    chk_ptrs("R6 drained");
    chk("R6 no overrun yet", overrun, 0);
    do_step();
    chk_ptrs("R6 blocked step");
    chk("R6 overrun set", overrun, 1);
    do_write(24'd1, 24'd2);
    exp_wr++; exp_fill++;
    chk("R6 overrun sticky", overrun, 1);
    do_cfg(8'd0);
    chk("R6 overrun cleared", overrun, 0);
    chk_ptrs("R6 realigned");
  endtask

  task automatic t_full();
    do_cfg(8'd0);
    for (int i = 0; i < 495; i++) begin
      do_write(24'(i), 24'(i));
      exp_wr = (exp_wr + 1) % 512; exp_fill++;
    end
    chk_ptrs("R7 at 511");
    chk("R7 no overrun yet", overrun, 0);
    do_write(24'd7, 24'd7);
    chk_ptrs("R7 dropped");
    chk("R7 overrun set", overrun, 1);
  endtask

  task automatic t_wrap();
    bit wrapped = 0;
    do_cfg(8'd0);
    for (int i = 0; i < 520; i++) begin
      @(negedge clk); in_valid = 1'b1; rd_step = 1'b1;
      @(negedge clk); in_valid = 1'b0; rd_step = 1'b0;
      exp_wr = (exp_wr + 1) % 512; exp_rd = (exp_rd + 1) % 512;
      if (exp_wr == 0) begin
        chk("R10 wr wrap", wr_addr, 0);
        wrapped = 1;
      end
      if (exp_rd == 0) chk("R10 rd wrap", rd_base, 0);
    end
    chk("R10 wrap seen", wrapped, 1);
    chk_ptrs("R10 after wrap");
  endtask

  task automatic t_mute();
    logic [23:0] d;
    int p;
    p = exp_wr;
    do_write(24'd1000, -24'sd2000);
    exp_wr = (exp_wr + 1) % 512; exp_fill++;
    do_cfg(8'h80);
    chk("R8 muted before ticks", muted, 0);
    read_word(10'(2 * p), d);
    chk("R8 unity left", d, 1000);
    do_ticks(32);
    read_word(10'(2 * p), d);
    chk("R8 half left", d, 500);
    read_word(10'(2 * p + 1), d);
    chk("R8 half right", $signed(d), -1000);
    do_ticks(32);
    read_word(10'(2 * p), d);
    chk("R8 silent left", d, 0);
    chk("R8 muted flag", muted, 1);
    do_ticks(5);
    chk("R8 floor hold", muted, 1);
    do_cfg(8'h00);
    chk("R9 still muted until tick", muted, 1);
    do_ticks(1);
    chk("R9 muted released", muted, 0);
    do_ticks(63);
    read_word(10'(2 * p + 1), d);
    chk("R9 restored right", $signed(d), -2000);
    do_ticks(10);
    read_word(10'(2 * p), d);
    chk("R9 unity cap", d, 1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_offset();
    t_step();
    t_overrun();
    t_full();
    t_wrap();
    t_mute();
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
      wait (done);
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule